// File: doc/BRIEF.md
# Clock Presence Monitor

This block decides whether a monitored clock is still toggling. It uses a slower reference clock as a timer: each low phase of the reference is a window, and that window must contain at least one falling edge of the monitored clock. The reference is always below half the monitored frequency, so a healthy clock always shows an edge in every window. The monitored clock, the reference clock and a stabilization tick are each brought into one system clock domain through synchronizer stages. Edges are found there by comparing successive samples. The system clock must run faster than twice the monitored clock.

A clock-off flag is raised after `MISS_LIMIT` consecutive windows that contain no edge. The flag drops on the first monitored falling edge seen while the reference is low. A clock-stable flag reports that the clock's generator has finished starting up. Parameter `STAB_SRC` picks the start-up event. In count mode, the event is the falling edge that brings the count of monitored falling edges since enable up to `STAB_CYCLES`. In tick mode, the event is a falling edge of the stabilization tick input. An internal clock pair and an external clock pair each take one instance.

Top module: `clock_presence_monitor`

## Requirements
- R1: While rst_ni is low, clk_off_o and clk_stable_o are 0, and the miss count is 0.
- R2: When a monitored falling edge lands in every reference-low window, clk_off_o stays 0.
- R3: clk_off_o rises at the end of the MISS_LIMIT-th consecutive edgeless reference-low window, where the end is the reference rising edge. Fewer edgeless windows leave it at 0. The default MISS_LIMIT is 2.
- R4: clk_off_o clears on the first monitored falling edge that occurs while the reference is low. Monitored falling edges while the reference is high leave it set.
- R5: With gen_en_i high and clk_off_o low, clk_stable_o sets on the start-up event. In count mode (STAB_SRC = STAB_COUNT) the event is the STAB_CYCLES-th monitored falling edge since gen_en_i rose. In tick mode (STAB_SRC = STAB_TICK) the event is a falling edge of stab_tick_i.
- R6: gen_en_i low clears clk_stable_o on the next clock, and it returns the start-up count to 0. After gen_en_i is raised again, STAB_CYCLES new monitored falling edges are needed before the flag sets.
- R7: clk_stable_o clears on the same clock on which clk_off_o sets. It cannot set while clk_off_o is high.
- R8: The miss count saturates at MISS_LIMIT. Any window that contains a monitored falling edge resets it to 0, so one edgeless window after a recovered window does not raise clk_off_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all sampling and state are in this domain |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mon_clk_i | input | 1 | Monitored clock, asynchronous |
| ref_clk_i | input | 1 | Slower reference clock, asynchronous; its low phase is the watch window |
| gen_en_i | input | 1 | Generator enable, synchronous to clk_i |
| stab_tick_i | input | 1 | Stabilization tick, asynchronous; its falling edge is used in tick mode |
| clk_off_o | output | 1 | Monitored clock judged stopped |
| clk_stable_o | output | 1 | Generator judged started and running |

## Verification
If the miss count is wrong, clk_off_o shows it one window early or late. The flag then rises at the reference rise after the first edgeless window instead of the second, or it fails to rise at all after a recovered window. These faults appear within one reference period plus the synchronizer delay. A start-up count that fails to restart, or a stable flag that is not tied to clk_off_o, shows up as clk_stable_o being high or low a full start-up interval away from where it should be. The bench sweeps 0 to 4 edgeless windows and samples each result in the middle of the following high phase.

// File: rtl/clk_act_pkg.sv
package clk_act_pkg;
  typedef enum logic {
    STAB_COUNT = 1'b0,
    STAB_TICK  = 1'b1
  } stab_src_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int W = STAGES + 1;

  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[W-2:0], d_i};
  end

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] the previous sample
  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/win_watch.sv
module win_watch #(
  parameter int MISS_LIMIT = 2,
  localparam int MW = $clog2(MISS_LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mon_fall_i,
  input  logic          ref_lvl_i,
  input  logic          ref_rise_i,
  output logic          off_o,
  output logic          off_set_o,
  output logic [MW-1:0] miss_o
);
  localparam logic [MW-1:0] LIM = MW'(MISS_LIMIT);

  logic          seen_q, off_q;
  logic [MW-1:0] miss_q, miss_d;
  logic          fall_low;

  assign fall_low = mon_fall_i & ~ref_lvl_i;

  always_comb begin
    miss_d    = miss_q;
    off_set_o = 1'b0;
    if (ref_rise_i) begin
      if (seen_q)            miss_d = '0;
      else if (miss_q != LIM) miss_d = miss_q + 1'b1;
      off_set_o = ~seen_q & (miss_q >= LIM - 1'b1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      miss_q <= '0;
      off_q  <= 1'b0;
    end else begin
      miss_q <= miss_d;
      if (ref_rise_i)    seen_q <= 1'b0;
      else if (fall_low) seen_q <= 1'b1;
      if (off_set_o)     off_q <= 1'b1;
      else if (fall_low) off_q <= 1'b0;
    end
  end

  assign off_o  = off_q;
  assign miss_o = miss_q;
endmodule

// File: rtl/stab_gate.sv
module stab_gate
  import clk_act_pkg::*;
#(
  parameter stab_src_e SRC    = STAB_COUNT,
  parameter int        CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gen_en_i,
  input  logic mon_fall_i,
  input  logic tick_fall_i,
  input  logic off_now_i,
  output logic stable_o
);
  logic evt;
  logic stable_q;

  if (SRC == STAB_COUNT) begin : g_count
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] TOP = CW'(CYCLES);
    logic [CW-1:0] cnt_q;
    logic          unused_tick;
    assign unused_tick = tick_fall_i;
    assign evt = gen_en_i & mon_fall_i & (cnt_q == TOP - 1'b1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      cnt_q <= '0;
      else if (!gen_en_i)               cnt_q <= '0;
      else if (mon_fall_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end
  end else begin : g_tick
    logic unused_mon;
    assign unused_mon = mon_fall_i;
    assign evt = gen_en_i & tick_fall_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    stable_q <= 1'b0;
    else if (!gen_en_i || off_now_i) stable_q <= 1'b0;
    else if (evt)                   stable_q <= 1'b1;
  end

  assign stable_o = stable_q;
endmodule

// File: rtl/clock_presence_monitor.sv
module clock_presence_monitor
  import clk_act_pkg::*;
#(
  parameter int        SYNC_STAGES = 2,
  parameter int        MISS_LIMIT  = 2,
  parameter int        STAB_CYCLES = 4096,
  parameter stab_src_e STAB_SRC    = STAB_COUNT,
  localparam int       MW          = $clog2(MISS_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_clk_i,
  input  logic ref_clk_i,
  input  logic gen_en_i,
  input  logic stab_tick_i,
  output logic clk_off_o,
  output logic clk_stable_o
);
  logic mon_lvl_w, mon_rise_w, mon_fall_w;
  logic ref_lvl_w, ref_rise_w, ref_fall_w;
  logic tick_lvl_w, tick_rise_w, tick_fall_w;
  logic off_w, off_set_w;
  logic [MW-1:0] miss_w;
  logic unused_edges;

  assign unused_edges = mon_lvl_w | mon_rise_w | ref_fall_w | tick_lvl_w | tick_rise_w;

  edge_sync #(.STAGES(SYNC_STAGES)) u_mon_sync (
    .clk_i, .rst_ni, .d_i(mon_clk_i),
    .lvl_o(mon_lvl_w), .rise_o(mon_rise_w), .fall_o(mon_fall_w)
  );

  edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk_i, .rst_ni, .d_i(ref_clk_i),
    .lvl_o(ref_lvl_w), .rise_o(ref_rise_w), .fall_o(ref_fall_w)
  );

  edge_sync #(.STAGES(SYNC_STAGES)) u_tick_sync (
    .clk_i, .rst_ni, .d_i(stab_tick_i),
    .lvl_o(tick_lvl_w), .rise_o(tick_rise_w), .fall_o(tick_fall_w)
  );

  win_watch #(.MISS_LIMIT(MISS_LIMIT)) u_win (
    .clk_i, .rst_ni,
    .mon_fall_i(mon_fall_w), .ref_lvl_i(ref_lvl_w), .ref_rise_i(ref_rise_w),
    .off_o(off_w), .off_set_o(off_set_w), .miss_o(miss_w)
  );

  stab_gate #(.SRC(STAB_SRC), .CYCLES(STAB_CYCLES)) u_stab (
    .clk_i, .rst_ni, .gen_en_i,
    .mon_fall_i(mon_fall_w), .tick_fall_i(tick_fall_w),
    .off_now_i(off_w | off_set_w),
    .stable_o(clk_stable_o)
  );

  assign clk_off_o = off_w;
endmodule

// File: rtl/clock_presence_monitor_sva.sv
module clock_presence_monitor_sva #(
  parameter int MISS_LIMIT = 2,
  parameter int MW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          gen_en_i,
  input logic          clk_off_o,
  input logic          clk_stable_o,
  input logic [MW-1:0] miss_q,
  input logic          mon_fall,
  input logic          ref_lvl
);
  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!clk_off_o && !clk_stable_o));

  p_off_at_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_off_o) |-> (miss_q == MW'(MISS_LIMIT)));

  p_off_clear_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_off_o) |-> $past(mon_fall && !ref_lvl));

  p_stable_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_stable_o) |-> ($past(gen_en_i) && !clk_off_o));

  p_en_low_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_en_i |=> !clk_stable_o);

  p_off_excl_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_off_o |-> !clk_stable_o);

  p_miss_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q <= MW'(MISS_LIMIT));
endmodule

bind clock_presence_monitor clock_presence_monitor_sva #(
  .MISS_LIMIT(MISS_LIMIT), .MW(MW)
) u_sva (
  .clk_i, .rst_ni, .gen_en_i, .clk_off_o, .clk_stable_o,
  .miss_q(miss_w), .mon_fall(mon_fall_w), .ref_lvl(ref_lvl_w)
);

// File: tb/sim_clock_presence_monitor.sv
module sim_clock_presence_monitor;
  localparam int REF_P = 40;
  localparam int MON_P = 8;
  localparam int STAB  = 8;
  localparam int LIM   = 2;
  localparam int MID_HIGH = 30;
  localparam int MID_LOW  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mon_clk = 1'b0, ref_clk = 1'b0, gen_en = 1'b0, tick = 1'b0;
  logic off0, st0, off1, st1;
  int   cyc = 0;
  bit   mon_run = 1'b1;
  bit   done = 1'b0;
  int   n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  // reference: low for cyc%REF_P < REF_P/2; monitored clock free-runs when enabled
  always @(negedge clk) begin
    cyc     <= cyc + 1;
    ref_clk <= ((cyc + 1) % REF_P) >= REF_P / 2;
    if (mon_run) mon_clk <= ((cyc + 1) % MON_P) < MON_P / 2;
  end

  clock_presence_monitor #(
    .MISS_LIMIT(LIM), .STAB_CYCLES(STAB), .STAB_SRC(clk_act_pkg::STAB_COUNT)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mon_clk_i(mon_clk), .ref_clk_i(ref_clk),
    .gen_en_i(gen_en), .stab_tick_i(1'b0), .clk_off_o(off0), .clk_stable_o(st0)
  );

  clock_presence_monitor #(
    .MISS_LIMIT(LIM), .STAB_CYCLES(STAB), .STAB_SRC(clk_act_pkg::STAB_TICK)
  ) u1 (
    .clk_i(clk), .rst_ni(rst_n), .mon_clk_i(mon_clk), .ref_clk_i(ref_clk),
    .gen_en_i(gen_en), .stab_tick_i(tick), .clk_off_o(off1), .clk_stable_o(st1)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic wait_ph(input int ph);
    do @(posedge clk); while (cyc % REF_P != ph);
    #1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    wait_cyc(4);
    tick = 1'b0;
    wait_cyc(8);
  endtask

  initial begin
    wait_cyc(5);
    chk(off0, 1'b0, "R1", "off in reset");
    chk(st0, 1'b0, "R1", "stable in reset");
    chk(off1, 1'b0, "R1", "off in reset u1");
    chk(st1, 1'b0, "R1", "stable in reset u1");
    wait_cyc(5);
    rst_n = 1'b1;

    // R2: healthy clock over several windows
    for (int w = 0; w < 4; w++) begin
      wait_ph(MID_HIGH);
      chk(off0, 1'b0, "R2", "healthy window");
    end

    // R5: count mode needs STAB falling edges (period MON_P)
    gen_en = 1'b1;
    wait_cyc(52);
    chk(st0, 1'b0, "R5", "count mode before STAB edges");
    wait_cyc(38);
    chk(st0, 1'b1, "R5", "count mode after STAB edges");
    chk(st1, 1'b0, "R5", "tick mode without tick");

    // R6: disable clears, re-enable restarts the count
    gen_en = 1'b0;
    wait_cyc(2);
    chk(st0, 1'b0, "R6", "enable low clears u0");
    gen_en = 1'b1;
    wait_cyc(52);
    chk(st0, 1'b0, "R6", "count restarted");
    wait_cyc(38);
    chk(st0, 1'b1, "R6", "set after fresh count");

    // R5: tick mode
    pulse_tick();
    chk(st1, 1'b1, "R5", "tick mode after tick fall");

    // R3/R4/R7/R8: sweep of edgeless window counts
    for (int k = 0; k <= 4; k++) begin
      mon_run = 1'b1;
      for (int w = 0; w < 3; w++) wait_ph(MID_HIGH);
      if (k >= LIM) begin
        gen_en = 1'b0; wait_cyc(2); gen_en = 1'b1;
        pulse_tick();
        wait_ph(MID_HIGH);
        chk(st1, 1'b1, "R5", "tick stable before loss");
      end
      mon_run = 1'b0;
      for (int w = 0; w < k; w++) wait_ph(MID_HIGH);
      chk(off0, (k >= LIM), "R3", $sformatf("off after %0d empty windows", k));
      if (k >= LIM) begin
        chk(st1, 1'b0, "R7", "stable cleared by off");
        // falling edges during reference high must not clear off
        mon_run = 1'b1;
        wait_ph(37);
        mon_run = 1'b0;
        wait_ph(39);
        chk(off0, 1'b1, "R4", "high-phase edges ignored");
        pulse_tick();
        chk(st1, 1'b0, "R7", "no set while off");
        wait_ph(MID_LOW);
        mon_run = 1'b1;
        wait_ph(18);
        chk(off0, 1'b0, "R4", "cleared by low-phase edge");
        pulse_tick();
        chk(st1, 1'b1, "R7", "set again once off clear");
      end
      mon_run = 1'b1;
      wait_ph(MID_HIGH);
      wait_ph(MID_HIGH);
      mon_run = 1'b0;
      wait_ph(MID_HIGH);
      chk(off0, 1'b0, "R8", "single empty window after recovery");
    end
    mon_run = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule